// File: doc/BRIEF.md
# Segmented Exponential SAR Conversion Sequencer

This block is the digital sequencer of an 8-bit successive-approximation converter whose transfer curve is a piecewise-linear approximation of an exponential, mirrored about a baseline. Small excursions from the baseline get fine steps. Large excursions get coarse steps. Each step doubles in size from one segment to the next. The sequencer drives the switch controls of the reference array and reads a single comparator decision in each cycle. It then returns the finished code together with a one-cycle completion strobe.

A conversion starts with a start pulse and runs four phases in a fixed order:

1. One polarity cycle compares the input against the baseline.
2. An auto-zero window lasts a parameterised number of cycles.
3. A three-step search picks the segment, and the segment index is presented to the array as a thermometer code.
4. A four-step search picks the position inside that segment.

The polarity decision becomes the code's top bit. When the input lies below the baseline, the array is flipped to its negated mirror. The remaining seven bits then measure the distance from the baseline downward.

Top module: `nlsar_seq`

## Requirements
- R1: After reset, `done`, `busy`, `dac_base`, `az_en`, `dac_neg`, `seg_therm`, `dac_lin` and `code` are all zero.
- R2: The cycle after a start is accepted, `dac_base` is high for exactly one cycle. `cmp_hi` sampled in that cycle becomes `code[7]`: 1 means at or above the baseline.
- R3: After the polarity cycle, `az_en` is high for exactly OFS_CYCLES cycles. `cmp_hi` has no effect on the result during that window.
- R4: The segment search takes three cycles and resolves `code[6:4]`, most significant bit first. In each cycle `seg_therm` shows the trial segment. The first trial is segment 4 (`seg_therm` = 7'b0001111).
- R5: `seg_therm` is always a thermometer code: segment s drives bits s-1..0 high and all higher bits low.
- R6: For an input at or above the baseline, `code[6:0]` is the largest index k = 16*s + l whose level 16*(2^s - 1) + l*2^s does not exceed the input's distance from the baseline, with s = code[6:4] and l = code[3:0].
- R7: For an input below the baseline, `code[7]` is 0 and `dac_neg` is high throughout both searches. `code[6:0]` is chosen by the same rule as in R6, using the distance below the baseline.
- R8: `done` rises exactly OFS_CYCLES + 9 cycles after the cycle in which start was driven. `code` is updated in that same cycle.
- R9: `done` is high for exactly one cycle per conversion.
- R10: A start pulse that arrives while `busy` is high has no effect. The conversion in progress keeps its timing and result, and no extra conversion follows.
- R11: `dac_lin` is nonzero only during the four in-segment cycles. Those cycles resolve `code[3:0]` most significant bit first, with `seg_therm` holding the chosen segment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, accepted only while idle |
| cmp_hi | input | 1 | Comparator: 1 when the input is at or beyond the presented level, away from the baseline |
| dac_base | output | 1 | Presents the baseline for the polarity decision |
| az_en | output | 1 | Auto-zero (offset cancellation) switch enable |
| dac_neg | output | 1 | Selects the mirrored lower half of the array |
| seg_therm | output | 7 | Thermometer-coded segment select for the array endpoints |
| dac_lin | output | 4 | In-segment step select |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle end-of-conversion strobe |
| code | output | 8 | Last converted code |

## Verification
The bench targets inputs that sit exactly on, or one step below, every one of the 128 level boundaries, in both halves, plus inputs beyond full scale. A design with an off-by-one in the segment scaling, or a wrong comparison sense, would return the neighbouring code at those points. A zero input must land in the upper half. The bench toggles the comparator at random during the auto-zero window, so a design that sampled it there would return scrambled codes. Extra start pulses, including one in the final in-segment cycle, would show up in a design that re-armed early as a shifted strobe or a second conversion.

// File: rtl/nlsar_pkg.sv
package nlsar_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_SIGN = 3'd1,
      ST_ZERO = 3'd2,
      ST_SEG  = 3'd3,
      ST_LIN  = 3'd4
   } seq_state_e;
endpackage

// File: rtl/nlsar_search.sv
module nlsar_search #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         step,
   input  logic         cmp,
   output logic [W-1:0] trial,
   output logic [W-1:0] value,
   output logic         last
);
   localparam logic [W-1:0] TOP_BIT = W'(1) << (W - 1);

   logic [W-1:0] val_q;
   logic [W-1:0] mask_q;

   generate
      if (W < 1) begin : g_bad_w
         $error("nlsar_search: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q  <= '0;
         mask_q <= '0;
      end else if (clear) begin
         val_q  <= '0;
         mask_q <= TOP_BIT;
      end else if (step) begin
         if (cmp) val_q <= val_q | mask_q;
         mask_q <= mask_q >> 1;
      end
   end

   assign trial = val_q | mask_q;
   assign value = val_q;
   assign last  = mask_q[0];

   // R4
   one_trial_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> $onehot(mask_q));
endmodule

// File: rtl/nlsar_therm.sv
module nlsar_therm #(
   parameter int BW = 3,
   localparam int TW = (1 << BW) - 1
) (
   input  logic [BW-1:0] bin,
   output logic [TW-1:0] therm
);
   generate
      for (genvar i = 0; i < TW; i++) begin : g_lvl
         assign therm[i] = (int'(bin) > i);
      end
   endgenerate
endmodule

// File: rtl/nlsar_ctrl.sv
module nlsar_ctrl
   import nlsar_pkg::*;
#(
   parameter int OFS_CYCLES = 4,
   localparam int CNT_W = (OFS_CYCLES > 1) ? $clog2(OFS_CYCLES) : 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       cmp,
   input  logic       seg_last,
   input  logic       lin_last,
   output seq_state_e state,
   output logic       sign_q,
   output logic       search_clear,
   output logic       seg_step,
   output logic       lin_step,
   output logic       finish
);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(OFS_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (OFS_CYCLES < 1) begin : g_bad_ofs
         $error("nlsar_ctrl: OFS_CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt_q  <= '0;
         sign_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (start) state <= ST_SIGN;
            ST_SIGN: begin
               sign_q <= cmp;
               cnt_q  <= '0;
               state  <= ST_ZERO;
            end
            ST_ZERO: begin
               if (cnt_q == CNT_END) state <= ST_SEG;
               else cnt_q <= cnt_q + 1'b1;
            end
            ST_SEG:  if (seg_last) state <= ST_LIN;
            ST_LIN:  if (lin_last) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign search_clear = (state == ST_IDLE) && start;
   assign seg_step     = (state == ST_SEG);
   assign lin_step     = (state == ST_LIN);
   assign finish       = (state == ST_LIN) && lin_last;

   // R2
   sign_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SIGN) |=> (state == ST_ZERO));

   // R3
   zero_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ZERO) |-> (cnt_q <= CNT_END));
endmodule

// File: rtl/nlsar_seq.sv
module nlsar_seq
   import nlsar_pkg::*;
#(
   parameter int SEG_W      = 3,
   parameter int LIN_W      = 4,
   parameter int OFS_CYCLES = 4,
   localparam int THERM_W   = (1 << SEG_W) - 1,
   localparam int CODE_W    = 1 + SEG_W + LIN_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               cmp_hi,
   output logic               dac_base,
   output logic               az_en,
   output logic               dac_neg,
   output logic [THERM_W-1:0] seg_therm,
   output logic [LIN_W-1:0]   dac_lin,
   output logic               busy,
   output logic               done,
   output logic [CODE_W-1:0]  code
);
   seq_state_e       state;
   logic             sign_q;
   logic             search_clear;
   logic             seg_step;
   logic             lin_step;
   logic             finish;
   logic [SEG_W-1:0] seg_trial;
   logic [SEG_W-1:0] seg_val;
   logic             seg_last;
   logic [LIN_W-1:0] lin_trial;
   logic [LIN_W-1:0] lin_val;
   logic             lin_last;
   logic [SEG_W-1:0] seg_show;

   generate
      if (SEG_W < 1 || SEG_W > 5) begin : g_bad_seg
         $error("nlsar_seq: SEG_W out of range 1..5");
      end
      if (LIN_W < 1) begin : g_bad_lin
         $error("nlsar_seq: LIN_W must be at least 1");
      end
   endgenerate

   nlsar_ctrl #(.OFS_CYCLES(OFS_CYCLES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .cmp(cmp_hi),
      .seg_last(seg_last), .lin_last(lin_last), .state(state),
      .sign_q(sign_q), .search_clear(search_clear), .seg_step(seg_step),
      .lin_step(lin_step), .finish(finish)
   );

   nlsar_search #(.W(SEG_W)) u_seg (
      .clk(clk), .rst_n(rst_n), .clear(search_clear), .step(seg_step),
      .cmp(cmp_hi), .trial(seg_trial), .value(seg_val), .last(seg_last)
   );

   nlsar_search #(.W(LIN_W)) u_lin (
      .clk(clk), .rst_n(rst_n), .clear(search_clear), .step(lin_step),
      .cmp(cmp_hi), .trial(lin_trial), .value(lin_val), .last(lin_last)
   );

   always_comb begin
      if (state == ST_SEG)      seg_show = seg_trial;
      else if (state == ST_LIN) seg_show = seg_val;
      else                      seg_show = '0;
   end

   nlsar_therm #(.BW(SEG_W)) u_therm (.bin(seg_show), .therm(seg_therm));

   assign dac_base = (state == ST_SIGN);
   assign az_en    = (state == ST_ZERO);
   assign dac_neg  = ((state == ST_SEG) || (state == ST_LIN)) && !sign_q;
   assign dac_lin  = (state == ST_LIN) ? lin_trial : '0;
   assign busy     = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0;
         code <= '0;
      end else begin
         done <= finish;
         if (finish) code <= {sign_q, seg_val, (cmp_hi ? lin_trial : lin_val)};
      end
   end

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));

   // R5
   therm_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((seg_therm & (seg_therm + 1'b1)) == '0));

   // R3
   az_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      az_en |-> (!dac_base && dac_lin == '0 && seg_therm == '0));

   // R11
   lin_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_lin != '0) |=> ((dac_lin != '0 && $stable(seg_therm)) || done));
endmodule

// File: tb/tb_nlsar_seq.sv
`timescale 1ns/1ps
module tb_nlsar_seq;
   localparam int OFS = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       cmp_hi;
   logic       dac_base, az_en, dac_neg, busy, done;
   logic [6:0] seg_therm;
   logic [3:0] dac_lin;
   logic [7:0] code;

   int  xin = 0;
   bit  noise = 1'b0;
   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;

   always #2 clk = ~clk;

   nlsar_seq #(.SEG_W(3), .LIN_W(4), .OFS_CYCLES(OFS)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmp_hi(cmp_hi),
      .dac_base(dac_base), .az_en(az_en), .dac_neg(dac_neg),
      .seg_therm(seg_therm), .dac_lin(dac_lin), .busy(busy),
      .done(done), .code(code)
   );

   function automatic int level(int s, int l);
      return 16 * ((1 << s) - 1) + l * (1 << s);
   endfunction

   function automatic int expect_code(int x);
      int mag = (x >= 0) ? x : -x;
      int best = 0;
      for (int k = 0; k < 128; k++)
         if (level(k >> 4, k & 15) <= mag) best = k;
      return ((x >= 0) ? 128 : 0) + best;
   endfunction

   // behavioural comparator of the mirrored piecewise-linear array
   always_comb begin
      int lv;
      lv = level($countones(seg_therm), int'(dac_lin));
      if (az_en)         cmp_hi = noise;
      else if (dac_base) cmp_hi = (xin >= 0);
      else if (dac_neg)  cmp_hi = (xin <= -lv);
      else               cmp_hi = (xin >= lv);
   end

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic convert(int x, bit inject);
      int  cyc = 0, done_at = -1, base_n = 0, az_n = 0, first_seg = -1;
      bit  therm_ok = 1'b1, lin_ok = 1'b1, neg_ok = 1'b1;
      xin = x;
      @(negedge clk);
      start = 1'b1;
      while (done_at < 0 && cyc < 40) begin
         @(negedge clk);
         cyc++;
         noise = ($urandom_range(0, 1) == 1);
         if (inject && (cyc == 4 || cyc == OFS + 8)) start = 1'b1;
         else start = 1'b0;
         if (dac_base) base_n++;
         if (az_en) az_n++;
         if (cyc == OFS + 2) first_seg = int'(seg_therm);
         if ((seg_therm & (seg_therm + 7'd1)) != 0) therm_ok = 1'b0;
         if ((cyc < OFS + 5 || cyc > OFS + 8) && dac_lin != 0) lin_ok = 1'b0;
         if (cyc >= OFS + 2 && cyc <= OFS + 8 && dac_neg != (x < 0)) neg_ok = 1'b0;
         if (done) done_at = cyc;
      end
      start = 1'b0;
      chk(base_n == 1, "R2 polarity cycle count", base_n, 1);
      chk(az_n == OFS, "R3 auto-zero window", az_n, OFS);
      chk(first_seg == 7'b0001111, "R4 first segment trial", first_seg, 15);
      chk(therm_ok, "R5 thermometer form", therm_ok, 1);
      chk(lin_ok, "R11 in-segment select outside window", lin_ok, 1);
      chk(neg_ok, "R7 mirror select", neg_ok, 1);
      chk(done_at == OFS + 9, inject ? "R10 latency with extra start" : "R8 latency",
          done_at, OFS + 9);
      if (x >= 0) chk(code == 8'(expect_code(x)), "R6 upper code", code, expect_code(x));
      else        chk(code == 8'(expect_code(x)), "R7 lower code", code, expect_code(x));
      @(negedge clk);
      chk(!done && !busy, "R9 done single cycle", done, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1
      chk(!done && !busy && !dac_base && !az_en && !dac_neg && seg_therm == 0
          && dac_lin == 0 && code == 0, "R1 reset state", code, 0);
      rst_n = 1'b1;
      @(negedge clk);
      convert(0, 1'b0);
      convert(-1, 1'b0);
      convert(5000, 1'b0);
      convert(-5000, 1'b0);
      for (int k = 0; k < 128; k++) begin
         convert(level(k >> 4, k & 15), 1'b0);
         convert(-level(k >> 4, k & 15), 1'b0);
         if (k > 0) begin
            convert(level(k >> 4, k & 15) - 1, 1'b0);
            convert(1 - level(k >> 4, k & 15), 1'b0);
         end
      end
      for (int x = -4050; x <= 4050; x += 37) convert(x, 1'b0);
      // R10: extra starts mid-conversion and in the final search cycle
      convert(1234, 1'b1);
      convert(-777, 1'b1);
      convert(3, 1'b1);
      begin
         int extra = 0;
         repeat (20) begin
            @(negedge clk);
            if (done || busy) extra++;
         end
         chk(extra == 0, "R10 no extra conversion", extra, 0);
      end
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule